// File: doc/BRIEF.md
# ISDN B-Channel Timeslot Port

This block turns a serial port into a 2B+D timing interface. Each frame has two B-channel slots. In the slot that the channel select picks, the block exchanges one 8-bit sample per frame. A static format input chooses between two slot layouts:

- **GCI**: one bit lasts two data clocks, B1 fills the first sixteen clocks of the frame and B2 the next sixteen.
- **IDL**: one bit per data clock, B1 starts right after the sync and B2 starts ten clocks later.

The block drives the serial output and its output enable only for the active bits of the chosen slot. It shifts the received bits of the same slot into a byte and marks that byte with a one-cycle strobe.

The data clock and the frame sync are ordinary inputs. A faster system clock samples them, and every level change seen on the data clock counts as one edge event. The format select is qualified over two frame starts. The channel select and the transmit byte are latched at each frame start, so changes inside a frame do nothing until the next frame.

Top module: `isdn_slot_port`

## Requirements
- R1: While reset is asserted, and after reset until the first recognised frame start, `sdo_oe`, `sdo` and `rx_valid` are 0, even if `dclk` toggles.
- R2: The active format comes out of reset as GCI (`fmt_sel`=0; IDL is 1). At each frame start `fmt_sel` is sampled. When this sample equals the sample taken at the previous frame start, the format switches to it. The new format applies from the next frame. A value held for only one frame start has no effect.
- R3: `ch_sel` (0 = B1, 1 = B2) is sampled at the frame start. Changes later in the same frame have no effect on that frame's transmit or receive slot.
- R4: In GCI, a frame starts at a rising `dclk` edge where `fsync` is 1 after being 0 at the previous rising edge. In IDL, a frame starts at a falling edge where `fsync` is 1 after being 0 at the previous falling edge. The start edge is edge 0 of the frame, and every later `dclk` edge counts one up.
- R5: GCI transmit. Bit i (MSB first) of the slot is driven from edge 4i for B1, or from edge 32+4i for B2. `sdo_oe` is 1 from the slot's first edge until the falling edge of the slot's 16th clock, which is edge 31 for B1 and edge 63 for B2.
- R6: IDL transmit. Bit i is driven from edge 1+2i for B1, the first rising edge after the start. For B2 it is driven from edge 21+2i, the eleventh rising edge. `sdo_oe` drops at the 8th falling edge (edge 16) for B1 and at the 18th (edge 36) for B2.
- R7: GCI receive. Bit i is sampled on the rising edge of the second clock of that bit, which is edge 2+4i for B1 and edge 34+4i for B2.
- R8: IDL receive. Bit i is sampled on falling edge 1+i for B1 (edge 2+2i) and on falling edge 11+i for B2 (edge 22+2i).
- R9: After the eighth received bit, `rx_valid` pulses for exactly one clock and `rx_byte` holds the byte, with the first received bit as the MSB. `rx_byte` changes only together with that pulse.
- R10: `sdo` is 0 whenever `sdo_oe` is 0. The line is never enabled in the unused slot.
- R11: The transmit byte is the value of `tx_byte` at the frame start. Changes later in the frame do not alter the bits sent.
- R12: `sdo` and `sdo_oe` settle within two `clk` cycles after the first `clk` edge that sees the new `dclk` level. A receive bit is taken from `sdi` one `clk` cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Serial data clock |
| fsync | input | 1 | Frame sync |
| sdi | input | 1 | Serial receive data |
| fmt_sel | input | 1 | Slot format: 0 GCI, 1 IDL |
| ch_sel | input | 1 | Channel: 0 B1, 1 B2 |
| tx_byte | input | 8 | Byte to send in the next frame |
| sdo | output | 1 | Serial transmit data |
| sdo_oe | output | 1 | Drive enable for the serial output |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new received byte |

## Verification
The bench attacks the slot edges in both formats. It checks the first and last edge of each enable window, so a design that released the line one edge late, or started B2 at the wrong offset, would fail on the release edge. It toggles the serial input between sample points, so a design that sampled in GCI on the first clock of a bit, or in IDL on rising edges, would capture the wrong bits. Mid-frame changes of the channel select and the transmit byte catch a design that failed to latch them at the frame start. A one-frame glitch on the format select catches a design that switched format without two agreeing samples.

// File: rtl/isdn_slot_pkg.sv
package isdn_slot_pkg;
  typedef enum logic {FMT_GCI = 1'b0, FMT_IDL = 1'b1} fmt_e;
  typedef enum logic {SLOT_B1 = 1'b0, SLOT_B2 = 1'b1} slot_e;
endpackage

// File: rtl/slot_frame_timer.sv
module slot_frame_timer
  import isdn_slot_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dclk,
  input  logic             fsync,
  input  logic             fmt_sel,
  input  logic             ch_sel,
  output logic [CNT_W-1:0] cnt_q,
  output logic             live_q,
  output fmt_e             fr_fmt_q,
  output slot_e            fr_slot_q,
  output logic             step_q,
  output logic             start_q
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic             dclk_q, fs_rise_q, fs_fall_q, hist_q;
  fmt_e             act_q, act_n;
  logic             fs_rise_n, fs_fall_n, hist_n, live_n;
  logic [CNT_W-1:0] cnt_n;
  fmt_e             fr_fmt_n;
  slot_e            fr_slot_n;
  logic             rise, fall, start;

  always_comb begin
    rise      = dclk & ~dclk_q;
    fall      = ~dclk & dclk_q;
    start     = (act_q == FMT_GCI) ? (rise & fsync & ~fs_rise_q)
                                   : (fall & fsync & ~fs_fall_q);
    fs_rise_n = rise ? fsync : fs_rise_q;
    fs_fall_n = fall ? fsync : fs_fall_q;
    cnt_n     = cnt_q;
    live_n    = live_q;
    fr_fmt_n  = fr_fmt_q;
    fr_slot_n = fr_slot_q;
    hist_n    = hist_q;
    act_n     = act_q;
    if (start) begin
      cnt_n     = '0;
      live_n    = 1'b1;
      fr_fmt_n  = act_q;
      fr_slot_n = slot_e'(ch_sel);
      hist_n    = fmt_sel;
      if (fmt_sel == hist_q) act_n = fmt_e'(fmt_sel);
    end else if ((rise | fall) && live_q && (cnt_q != CNT_TOP)) begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q    <= 1'b0;
      fs_rise_q <= 1'b0;
      fs_fall_q <= 1'b0;
      hist_q    <= 1'b0;
      act_q     <= FMT_GCI;
      cnt_q     <= '0;
      live_q    <= 1'b0;
      fr_fmt_q  <= FMT_GCI;
      fr_slot_q <= SLOT_B1;
      step_q    <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      dclk_q    <= dclk;
      fs_rise_q <= fs_rise_n;
      fs_fall_q <= fs_fall_n;
      hist_q    <= hist_n;
      act_q     <= act_n;
      cnt_q     <= cnt_n;
      live_q    <= live_n;
      fr_fmt_q  <= fr_fmt_n;
      fr_slot_q <= fr_slot_n;
      step_q    <= rise | fall;
      start_q   <= start;
    end
  end

  p_start_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (cnt_q == '0) && live_q);
  p_fmt_frame_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n_chk |=> $stable(fr_fmt_q));
  p_slot_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n_chk |=> $stable(fr_slot_q));

  logic start_n_chk;
  assign start_n_chk = start;
endmodule

// File: rtl/slot_tx.sv
module slot_tx
  import isdn_slot_pkg::*;
#(
  parameter int DW       = 8,
  parameter int IDL_GAP  = 10,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             live,
  input  fmt_e             fr_fmt,
  input  slot_e            fr_slot,
  input  logic             start,
  input  logic [DW-1:0]    tx_byte,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNT_W-1:0] G_B2   = CNT_W'(4 * DW);
  localparam logic [CNT_W-1:0] I_B1   = CNT_W'(1);
  localparam logic [CNT_W-1:0] I_B2   = CNT_W'(2 * IDL_GAP + 1);
  localparam logic [CNT_W-1:0] G_LAST = CNT_W'(4 * DW - 2);
  localparam logic [CNT_W-1:0] I_LAST = CNT_W'(2 * DW - 2);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DW - 1);

  logic [DW-1:0]    held_q, word;
  logic [CNT_W-1:0] base, last, off;
  logic [IDX_W-1:0] idx, sel;
  logic             win, sdo_n;

  always_comb begin
    if (fr_fmt == FMT_GCI) begin
      base = (fr_slot == SLOT_B2) ? G_B2 : '0;
      last = G_LAST;
    end else begin
      base = (fr_slot == SLOT_B2) ? I_B2 : I_B1;
      last = I_LAST;
    end
    off  = cnt - base;
    idx  = (fr_fmt == FMT_GCI) ? off[IDX_W+1:2] : off[IDX_W:1];
    sel  = TOP_IDX - idx;
    word = start ? tx_byte : held_q;
    win  = live && (cnt >= base) && (off <= last);
    sdo_n = win ? word[sel] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      if (start) held_q <= tx_byte;
      sdo    <= sdo_n;
      sdo_oe <= win;
    end
  end

  p_quiet_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  p_drive_after_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> live);
  p_word_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(held_q));
endmodule

// File: rtl/slot_rx.sv
module slot_rx
  import isdn_slot_pkg::*;
#(
  parameter int DW      = 8,
  parameter int IDL_GAP = 10,
  parameter int CNT_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             live,
  input  logic             step,
  input  fmt_e             fr_fmt,
  input  slot_e            fr_slot,
  input  logic             sdi,
  output logic [DW-1:0]    rx_byte,
  output logic             rx_valid
);
  localparam logic [CNT_W-1:0] G_B1   = CNT_W'(2);
  localparam logic [CNT_W-1:0] G_B2   = CNT_W'(4 * DW + 2);
  localparam logic [CNT_W-1:0] I_B1   = CNT_W'(2);
  localparam logic [CNT_W-1:0] I_B2   = CNT_W'(2 * IDL_GAP + 2);
  localparam logic [CNT_W-1:0] G_SPAN = CNT_W'(4 * (DW - 1));
  localparam logic [CNT_W-1:0] I_SPAN = CNT_W'(2 * (DW - 1));

  logic [DW-1:0]    sh_q, sh_n, byte_n;
  logic [CNT_W-1:0] base, span, off;
  logic             aligned, hit, last, valid_n;

  always_comb begin
    if (fr_fmt == FMT_GCI) begin
      base    = (fr_slot == SLOT_B2) ? G_B2 : G_B1;
      span    = G_SPAN;
    end else begin
      base    = (fr_slot == SLOT_B2) ? I_B2 : I_B1;
      span    = I_SPAN;
    end
    off     = cnt - base;
    aligned = (fr_fmt == FMT_GCI) ? (off[1:0] == 2'b00) : ~off[0];
    hit     = step && live && (cnt >= base) && (off <= span) && aligned;
    last    = hit && (off == span);
    sh_n    = hit ? {sh_q[DW-2:0], sdi} : sh_q;
    byte_n  = last ? {sh_q[DW-2:0], sdi} : rx_byte;
    valid_n = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      sh_q     <= sh_n;
      rx_byte  <= byte_n;
      rx_valid <= valid_n;
    end
  end

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_byte_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_byte));
endmodule

// File: rtl/isdn_slot_port.sv
module isdn_slot_port
  import isdn_slot_pkg::*;
#(
  parameter int DW      = 8,
  parameter int IDL_GAP = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dclk,
  input  logic          fsync,
  input  logic          sdi,
  input  logic          fmt_sel,
  input  logic          ch_sel,
  input  logic [DW-1:0] tx_byte,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid
);
  localparam int GCI_END = 8 * DW;
  localparam int IDL_END = 2 * IDL_GAP + 2 * DW + 2;
  localparam int NEED    = (GCI_END > IDL_END) ? GCI_END : IDL_END;
  localparam int CNT_W   = $clog2(NEED + 1);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [CNT_W-1:0] cnt;
  logic             live, step, start;
  fmt_e             fr_fmt;
  slot_e            fr_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  slot_frame_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .dclk(dclk), .fsync(fsync),
    .fmt_sel(fmt_sel), .ch_sel(ch_sel), .cnt_q(cnt), .live_q(live),
    .fr_fmt_q(fr_fmt), .fr_slot_q(fr_slot), .step_q(step), .start_q(start)
  );

  slot_tx #(.DW(DW), .IDL_GAP(IDL_GAP), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .cnt(cnt), .live(live), .fr_fmt(fr_fmt),
    .fr_slot(fr_slot), .start(start), .tx_byte(tx_byte),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  slot_rx #(.DW(DW), .IDL_GAP(IDL_GAP), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .cnt(cnt), .live(live), .step(step),
    .fr_fmt(fr_fmt), .fr_slot(fr_slot), .sdi(sdi),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );
endmodule

// File: tb/test_isdn_slot_port.sv
module test_isdn_slot_port;
  logic       clk, rst_n, dclk, fsync, sdi, fmt_sel, ch_sel;
  logic [7:0] tx_byte;
  logic       sdo, sdo_oe, rx_valid;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0;
  int vcnt = 0;
  logic [7:0] vbyte;
  int act = 0, hist = 0;
  bit done = 0;

  isdn_slot_port i_isdn_slot_port (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .fsync(fsync), .sdi(sdi),
    .fmt_sel(fmt_sel), .ch_sel(ch_sel), .tx_byte(tx_byte),
    .sdo(sdo), .sdo_oe(sdo_oe), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  always @(negedge clk) if (rx_valid) begin vcnt++; vbyte = rx_byte; end

  task automatic check(input bit ok, input string req, input int actv, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actv, expv, $time);
    end
  endtask

  function automatic bit rx_point(input int f, input int c, input int k, output int idx);
    int base = (f == 0) ? (c ? 34 : 2) : (c ? 22 : 2);
    int str  = (f == 0) ? 4 : 2;
    int off  = k - base;
    idx = off / str;
    return (off >= 0) && (off <= str * 7) && (off % str == 0);
  endfunction

  task automatic run_frame(input int c, input logic [7:0] tb, input logic [7:0] rb, input bit mid);
    int f = act;
    int idx;
    ch_sel = c[0]; tx_byte = tb; vcnt = 0;
    for (int k = -2; k < 78; k++) begin
      @(negedge clk);
      dclk  = (f == 0) ? (((k + 2) % 2) == 0) : (((k + 2) % 2) != 0);
      fsync = (f == 0) ? (k >= -1 && k <= 2) : (k >= -1 && k <= 0);
      if (rx_point(f, c, k + 1, idx)) sdi = rb[7 - idx];
      else if (!rx_point(f, c, k, idx)) sdi = ~sdi;
      if (mid && k == 20) begin ch_sel = ~c[0]; tx_byte = ~tb; end
      repeat (3) @(negedge clk);
      begin
        int tb0 = (f == 0) ? (c ? 32 : 0) : (c ? 21 : 1);
        int str = (f == 0) ? 4 : 2;
        int off = k - tb0;
        bit eoe = (k >= 0) && (off >= 0) && (off <= str * 8 - 2);
        bit esd = eoe ? tb[7 - off / str] : 1'b0;
        string rq = !eoe ? "R10" : (f == 0 ? "R5" : "R6");
        check(sdo_oe === eoe, rq, sdo_oe, eoe);
        check(sdo === esd, rq, sdo, esd);
      end
    end
    check(vcnt == 1, "R9", vcnt, 1);
    check(vbyte === rb, (f == 0) ? "R7" : "R8", vbyte, rb);
    if (fmt_sel == hist[0]) act = fmt_sel;
    hist = fmt_sel;
  endtask

  initial begin
    rst_n = 0; dclk = 0; fsync = 0; sdi = 0; fmt_sel = 0; ch_sel = 0; tx_byte = 8'h00;
    repeat (3) @(negedge clk);
    check(sdo_oe === 1'b0 && sdo === 1'b0 && rx_valid === 1'b0, "R1", sdo_oe, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(sdo_oe === 1'b0 && rx_valid === 1'b0, "R1", sdo_oe, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); dclk = ~dclk; tx_byte = 8'hFF;
      repeat (3) @(negedge clk);
      check(sdo_oe === 1'b0 && sdo === 1'b0, "R1", sdo_oe, 0);
    end
    check(vcnt == 0, "R1", vcnt, 0);
    run_frame(0, 8'hA5, 8'h3C, 0);
    run_frame(1, 8'h96, 8'hE1, 1);            // R3 R11 mid-frame changes
    fmt_sel = 1;
    run_frame(0, 8'h01, 8'h80, 0);            // R2 first sample: still GCI
    run_frame(1, 8'hFF, 8'h00, 0);            // R2 second sample: switch after
    run_frame(0, 8'h80, 8'h01, 0);
    run_frame(1, 8'hC3, 8'h7E, 1);            // R3 R11 in IDL
    fmt_sel = 0;
    run_frame(0, 8'h5A, 8'hB4, 0);            // R2 glitch frame
    fmt_sel = 1;
    run_frame(1, 8'h0F, 8'hF0, 0);
    fmt_sel = 0;
    run_frame(0, 8'h69, 8'h96, 0);
    run_frame(1, 8'h33, 8'hCC, 0);
    run_frame(1, 8'h7E, 8'h81, 0);            // R4 back in GCI
    run_frame(0, 8'hE7, 8'h18, 0);
    check(act == 0, "R2", act, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R12: watchdog expired actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule